// File: doc/BRIEF.md
# Link-Training Coefficient Requester

This block is the transmit-side tuning controller of a backplane link-training exchange. It drives the coefficient-update word sent to the link partner. It reads back the partner's six-bit status reply and, when it asks for one, receives an early/late verdict for two receiver bins. The first is the long bin, which steers the post-cursor tap c(+1). The second is the M1 bin, which steers the pre-cursor tap c(-1).

After reset the block asks the partner to INITIALIZE, a single time. It waits for that request to be acknowledged. From then on it returns each coefficient request to HOLD as soon as the partner replies to it. Once the outgoing word has stopped changing, it asks for a fresh bin evaluation and converts the two verdicts into new increment or decrement requests. The long bin is always finished before the M1 bin is worked on. A bin stops either after repeated saturation replies or when its verdict crosses over. When both bins have stopped, the block raises receiver-ready and tuning-complete and holds them until reset.

Top module: `lt_coef_requester`

## Requirements
- R1: After reset, coef_update is zero and bin_eval_req, rx_ready and tune_done are low. In coef_update, bit 12 is INITIALIZE, bit 13 is PRESET, bits 5:4 hold the c(+1) request, bits 3:2 hold the c(0) request and bits 1:0 hold the c(-1) request. Request codes are 0 HOLD, 1 INCREMENT and 2 DECREMENT. The c(0) field always stays HOLD.
- R2: INITIALIZE is raised exactly once between resets. It is raised in a cycle where lp_status is all zero and bits 13, 12 and 5:0 of coef_update are all clear.
- R3: lp_status carries one two-bit status per coefficient at the same bit positions as the requests. Status codes are 0 NOT_UPDATED, 1 UPDATED, 2 MINIMUM and 3 MAXIMUM. A pending INITIALIZE is cleared only when none of the three statuses is NOT_UPDATED.
- R4: A pending request on a coefficient whose status is not NOT_UPDATED returns to HOLD.
- R5: A returned DECREMENT answered with MINIMUM, or a returned INCREMENT answered with MAXIMUM, counts one saturation for that coefficient's bin: c(+1) belongs to the long bin and c(-1) to the M1 bin. The third saturation stops that bin.
- R6: A new request is placed only while PRESET and INITIALIZE are both clear, that coefficient's status is NOT_UPDATED and no request is already pending on it.
- R7: While the long bin is active, each evaluation requests INCREMENT on c(+1) if the long bin is early and DECREMENT otherwise. In the same evaluation, it requests DECREMENT on c(-1) only if the M1 bin is not early.
- R8: bin_eval_req rises only after a cycle in which the outgoing word did not change. It stays high until bin_eval_done is seen, and the verdicts are sampled in that same cycle.
- R9: Once the long bin has stopped, no new c(+1) request is placed. c(-1) receives INCREMENT if the M1 bin is early and DECREMENT otherwise.
- R10: The long bin stops on a late verdict when its last recorded verdict was early. The M1 bin stops on an early verdict when its last recorded verdict was late. The recorded long verdict starts as late and the recorded M1 verdict starts as early. Each bin records its verdict whenever a request is placed for it. An evaluation that stops a bin places no request.
- R11: When both bins have stopped, rx_ready and tune_done go high and stay high until reset. After that, no further evaluation is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_status | input | 6 | Partner status reply, three two-bit fields |
| bin_eval_done | input | 1 | Bin verdicts valid this cycle |
| bin_m1_early | input | 1 | M1 bin verdict, 1 = early |
| bin_long_early | input | 1 | Long bin verdict, 1 = early |
| coef_update | output | 16 | Outgoing coefficient-update word |
| bin_eval_req | output | 1 | Request for a new bin evaluation |
| rx_ready | output | 1 | Local receiver-ready status bit |
| tune_done | output | 1 | Transmit tuning complete |

## Verification
The assertions check the following on every cycle:
- the single rise of INITIALIZE;
- the return to HOLD of a c(+1) request that has been answered;
- the absence of new requests while INITIALIZE is pending;
- the hold-until-done behaviour of the evaluation request;
- the stickiness of the ready outputs, and that both bins must have stopped before they rise.

The bench scenarios are needed for the behaviour that depends on history: the saturation count reaching three, the crossover stops against the recorded verdicts, the long-before-M1 ordering, and the exact request codes chosen from each verdict pair.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;
  localparam int UPD_W      = 16;
  localparam int PRESET_BIT = 13;
  localparam int INIT_BIT   = 12;
  localparam int NUM_COEF   = 3;
  localparam logic [UPD_W-1:0] PEND_MASK = 16'h303F;

  typedef enum logic [1:0] {REQ_HOLD = 2'd0, REQ_INC = 2'd1, REQ_DEC = 2'd2} req_e;
  typedef enum logic [1:0] {ST_NOTUPD = 2'd0, ST_UPD = 2'd1, ST_MIN = 2'd2, ST_MAX = 2'd3} stat_e;
  typedef enum logic [1:0] {PH_SETTLE = 2'd0, PH_EVAL = 2'd1, PH_DONE = 2'd2} phase_e;

  // A returned request hit the end of the coefficient's range.
  function automatic logic sat_reply(logic [1:0] req, logic [1:0] st);
    return (req == 2'(REQ_DEC) && st == 2'(ST_MIN)) ||
           (req == 2'(REQ_INC) && st == 2'(ST_MAX));
  endfunction
endpackage

// File: rtl/lt_hold_logic.sv
`timescale 1ns/1ps
module lt_hold_logic
  import lt_pkg::*;
(
  input  logic [UPD_W-1:0] word_q,
  input  logic [5:0]       lp_status,
  input  logic             init_sent_q,
  output logic [UPD_W-1:0] word_d,
  output logic             init_fire,
  output logic             sat_long,
  output logic             sat_m1
);
  logic none_notupd;

  assign none_notupd = (lp_status[5:4] != 2'b00) && (lp_status[3:2] != 2'b00) &&
                       (lp_status[1:0] != 2'b00);
  assign init_fire   = !init_sent_q && (lp_status == 6'd0) && ((word_q & PEND_MASK) == '0);
  assign sat_long    = (lp_status[5:4] != 2'b00) && sat_reply(word_q[5:4], lp_status[5:4]);
  assign sat_m1      = (lp_status[1:0] != 2'b00) && sat_reply(word_q[1:0], lp_status[1:0]);

  always_comb begin
    word_d = word_q;
    if (word_q[INIT_BIT] && none_notupd) word_d[INIT_BIT] = 1'b0;
    if (init_fire) word_d[INIT_BIT] = 1'b1;
    for (int i = 0; i < NUM_COEF; i++) begin
      if (lp_status[2*i +: 2] != 2'b00 && word_q[2*i +: 2] != 2'b00)
        word_d[2*i +: 2] = 2'(REQ_HOLD);
    end
  end
endmodule

// File: rtl/lt_bin_tracker.sv
`timescale 1ns/1ps
module lt_bin_tracker #(
  parameter bit TRIG_EARLY = 1'b1,
  parameter int SAT_LIMIT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sat_hit,
  input  logic verdict_vld,
  input  logic verdict_early,
  input  logic rec_en,
  input  logic rec_val,
  output logic stop_q,
  output logic verdict_stop
);
  localparam int CNT_W = (SAT_LIMIT < 2) ? 1 : $clog2(SAT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAT_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             rec_q;

  // Crossover: verdict equals the trigger sense after a record of the other sense.
  assign verdict_stop = verdict_vld && !stop_q && (verdict_early == TRIG_EARLY) &&
                        (rec_q != TRIG_EARLY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
      rec_q  <= TRIG_EARLY;
    end else begin
      if (sat_hit && !stop_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_CNT) stop_q <= 1'b1;
      end
      if (verdict_stop) stop_q <= 1'b1;
      if (rec_en) rec_q <= rec_val;
    end
  end
endmodule

// File: rtl/lt_coef_requester.sv
`timescale 1ns/1ps
module lt_coef_requester
  import lt_pkg::*;
#(
  parameter int SAT_LIMIT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  lp_status,
  input  logic        bin_eval_done,
  input  logic        bin_m1_early,
  input  logic        bin_long_early,
  output logic [15:0] coef_update,
  output logic        bin_eval_req,
  output logic        rx_ready,
  output logic        tune_done
);
  phase_e           ph_q;
  logic [UPD_W-1:0] word_q, word_d;
  logic init_sent_q, init_fire, sat_long_raw, sat_m1_raw;
  logic long_stop, m1_stop, long_vstop, m1_vstop;

  // Named internal events
  logic settle_active, word_moves, eval_fire, req_open;
  logic ask_p1, ask_m1_long, ask_m1_tune;

  assign settle_active = (ph_q == PH_SETTLE) && !(long_stop && m1_stop);
  assign word_moves    = settle_active && (word_d != word_q);
  assign eval_fire     = (ph_q == PH_EVAL) && bin_eval_done;
  assign req_open      = eval_fire && !long_vstop && !m1_vstop &&
                         !word_q[INIT_BIT] && !word_q[PRESET_BIT];
  assign ask_p1        = req_open && !long_stop && lp_status[5:4] == 2'b00 && word_q[5:4] == 2'b00;
  assign ask_m1_long   = req_open && !long_stop && lp_status[1:0] == 2'b00 &&
                         word_q[1:0] == 2'b00 && !bin_m1_early;
  assign ask_m1_tune   = req_open && long_stop && !m1_stop && lp_status[1:0] == 2'b00 &&
                         word_q[1:0] == 2'b00;

  lt_hold_logic u_hold (
    .word_q      (word_q),
    .lp_status   (lp_status),
    .init_sent_q (init_sent_q),
    .word_d      (word_d),
    .init_fire   (init_fire),
    .sat_long    (sat_long_raw),
    .sat_m1      (sat_m1_raw)
  );

  lt_bin_tracker #(.TRIG_EARLY(1'b0), .SAT_LIMIT(SAT_LIMIT)) u_long_bin (
    .clk           (clk),
    .rst_n         (rst_n),
    .sat_hit       (word_moves && sat_long_raw),
    .verdict_vld   (eval_fire),
    .verdict_early (bin_long_early),
    .rec_en        (ask_p1),
    .rec_val       (bin_long_early),
    .stop_q        (long_stop),
    .verdict_stop  (long_vstop)
  );

  lt_bin_tracker #(.TRIG_EARLY(1'b1), .SAT_LIMIT(SAT_LIMIT)) u_m1_bin (
    .clk           (clk),
    .rst_n         (rst_n),
    .sat_hit       (word_moves && sat_m1_raw),
    .verdict_vld   (eval_fire),
    .verdict_early (bin_m1_early),
    .rec_en        (ask_m1_long || ask_m1_tune),
    .rec_val       (bin_m1_early),
    .stop_q        (m1_stop),
    .verdict_stop  (m1_vstop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q        <= PH_SETTLE;
      word_q      <= '0;
      init_sent_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_SETTLE: begin
          if (long_stop && m1_stop) ph_q <= PH_DONE;
          else if (word_d != word_q) begin
            word_q <= word_d;
            if (init_fire) init_sent_q <= 1'b1;
          end else ph_q <= PH_EVAL;
        end
        PH_EVAL: begin
          if (bin_eval_done) begin
            ph_q <= PH_SETTLE;
            if (ask_p1) word_q[5:4] <= bin_long_early ? 2'(REQ_INC) : 2'(REQ_DEC);
            if (ask_m1_long) word_q[1:0] <= 2'(REQ_DEC);
            if (ask_m1_tune) word_q[1:0] <= bin_m1_early ? 2'(REQ_INC) : 2'(REQ_DEC);
          end
        end
        default: ph_q <= PH_DONE;
      endcase
    end
  end

  assign coef_update  = word_q;
  assign bin_eval_req = (ph_q == PH_EVAL);
  assign rx_ready     = (ph_q == PH_DONE);
  assign tune_done    = (ph_q == PH_DONE);
endmodule

// File: rtl/lt_coef_requester_chk.sv
`timescale 1ns/1ps
module lt_coef_requester_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] coef_update,
  input logic [1:0]  lp_p1,
  input logic        bin_eval_req,
  input logic        bin_eval_done,
  input logic        rx_ready,
  input logic        tune_done,
  input logic        settle_active,
  input logic        long_stop,
  input logic        m1_stop
);
  logic       prev_init;
  logic [1:0] init_rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_init  <= 1'b0;
      init_rises <= 2'd0;
    end else begin
      prev_init <= coef_update[12];
      if (coef_update[12] && !prev_init && init_rises != 2'd3) init_rises <= init_rises + 2'd1;
    end
  end

  a_r2_init_once: assert property (@(posedge clk) disable iff (!rst_n) init_rises <= 2'd1);

  a_r4_hold_p1: assert property (@(posedge clk) disable iff (!rst_n)
    settle_active && coef_update[5:4] != 2'b00 && lp_p1 != 2'b00 |=> coef_update[5:4] == 2'b00);

  a_r6_no_p1_under_init: assert property (@(posedge clk) disable iff (!rst_n)
    coef_update[12] && coef_update[5:4] == 2'b00 |=> coef_update[5:4] == 2'b00);

  a_r6_no_m1_under_init: assert property (@(posedge clk) disable iff (!rst_n)
    coef_update[12] && coef_update[1:0] == 2'b00 |=> coef_update[1:0] == 2'b00);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bin_eval_req && !bin_eval_done |=> bin_eval_req);

  a_r8_req_released: assert property (@(posedge clk) disable iff (!rst_n)
    bin_eval_req && bin_eval_done |=> !bin_eval_req);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tune_done |=> tune_done && rx_ready);

  a_r11_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> long_stop && m1_stop);

  always @(posedge clk) begin
    if (rst_n) begin
      a_r1_legal_codes: assert (coef_update[3:2] == 2'b00 && coef_update[5:4] != 2'b11 &&
                                coef_update[1:0] != 2'b11);
    end
  end
endmodule

bind lt_coef_requester lt_coef_requester_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .coef_update   (coef_update),
  .lp_p1         (lp_status[5:4]),
  .bin_eval_req  (bin_eval_req),
  .bin_eval_done (bin_eval_done),
  .rx_ready      (rx_ready),
  .tune_done     (tune_done),
  .settle_active (settle_active),
  .long_stop     (long_stop),
  .m1_stop       (m1_stop)
);

// File: tb/lt_coef_requester_bench.sv
`timescale 1ns/1ps
module lt_coef_requester_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  lp_status = 6'd0;
  logic        bin_eval_done = 1'b0, bin_m1_early = 1'b0, bin_long_early = 1'b0;
  logic [15:0] coef_update;
  logic        bin_eval_req, rx_ready, tune_done;

  always #10 clk = ~clk;

  lt_coef_requester u_lt_coef_requester (
    .clk(clk), .rst_n(rst_n), .lp_status(lp_status), .bin_eval_done(bin_eval_done),
    .bin_m1_early(bin_m1_early), .bin_long_early(bin_long_early),
    .coef_update(coef_update), .bin_eval_req(bin_eval_req),
    .rx_ready(rx_ready), .tune_done(tune_done)
  );

  int n_chk = 0, n_fail = 0;

  // Bench reference state
  logic [15:0] m_w;
  bit m_sent, m_sl, m_sm, m_rl, m_rm;
  int m_cl, m_cm, m_ph;

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit hit_end(logic [1:0] r, logic [1:0] s);
    return (r == 2'd1 && s == 2'd3) || (r == 2'd2 && s == 2'd2);
  endfunction

  task automatic m_reset();
    m_w = 16'h0; m_sent = 0; m_cl = 0; m_cm = 0; m_sl = 0; m_sm = 0;
    m_rl = 0; m_rm = 1; m_ph = 0;
  endtask

  task automatic m_step(logic [5:0] st, bit d, bit me, bit le);
    logic [15:0] nw;
    bit halt;
    halt = 0;
    if (m_ph == 0) begin
      if (m_sl && m_sm) m_ph = 2;
      else begin
        nw = m_w;
        if (m_w[12] && st[5:4] != 0 && st[3:2] != 0 && st[1:0] != 0) nw[12] = 0;   // R3
        if (!m_sent && st == 0 && (m_w & 16'h303F) == 0) nw[12] = 1;              // R2
        if (st[5:4] != 0 && m_w[5:4] != 0) nw[5:4] = 0;                           // R4
        if (st[3:2] != 0 && m_w[3:2] != 0) nw[3:2] = 0;
        if (st[1:0] != 0 && m_w[1:0] != 0) nw[1:0] = 0;
        if (nw != m_w) begin
          if (nw[12] && !m_w[12]) m_sent = 1;
          if (st[5:4] != 0 && hit_end(m_w[5:4], st[5:4]) && !m_sl) begin          // R5
            m_cl++; if (m_cl >= 3) m_sl = 1;
          end
          if (st[1:0] != 0 && hit_end(m_w[1:0], st[1:0]) && !m_sm) begin
            m_cm++; if (m_cm >= 3) m_sm = 1;
          end
          m_w = nw;
        end else m_ph = 1;
      end
    end else if (m_ph == 1 && d) begin
      if (!m_sm && me && !m_rm) begin m_sm = 1; halt = 1; end                     // R10
      if (!m_sl && !le && m_rl) begin m_sl = 1; halt = 1; end
      if (!halt && !m_w[12] && !m_w[13]) begin                                      // R6
        if (!m_sl) begin                                                            // R7
          if (st[1:0] == 0 && m_w[1:0] == 0 && !me) begin m_w[1:0] = 2; m_rm = 0; end
          if (st[5:4] == 0 && m_w[5:4] == 0) begin m_w[5:4] = le ? 2'd1 : 2'd2; m_rl = le; end
        end else if (!m_sm) begin                                                   // R9
          if (st[1:0] == 0 && m_w[1:0] == 0) begin m_w[1:0] = me ? 2'd1 : 2'd2; m_rm = me; end
        end
      end
      m_ph = 0;
    end
  endtask

  task automatic cyc(logic [5:0] st, bit d, bit me, bit le);
    lp_status = st; bin_eval_done = d; bin_m1_early = me; bin_long_early = le;
    m_step(st, d, me, le);
    @(negedge clk);
    chk(coef_update == m_w, "R4 coef_update vs model", coef_update, m_w);
    chk(bin_eval_req == (m_ph == 1), "R8 bin_eval_req vs model", 16'(bin_eval_req), 16'(m_ph == 1));
    chk(rx_ready == (m_ph == 2), "R11 rx_ready vs model", 16'(rx_ready), 16'(m_ph == 2));
    chk(tune_done == (m_ph == 2), "R11 tune_done vs model", 16'(tune_done), 16'(m_ph == 2));
  endtask

  task automatic do_reset();
    rst_n = 0; lp_status = 0; bin_eval_done = 0; bin_m1_early = 0; bin_long_early = 0;
    m_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    chk(coef_update == 16'h0, "R1 reset word", coef_update, 16'h0);
    chk(!bin_eval_req && !rx_ready && !tune_done, "R1 reset flags",
        16'({bin_eval_req, rx_ready, tune_done}), 16'h0);
  endtask

  task automatic run_eval(logic [5:0] st, bit me, bit le);
    for (int k = 0; k < 8 && !bin_eval_req; k++) cyc(st, 0, 0, 0);
    chk(bin_eval_req, "R8 evaluation requested", 16'(bin_eval_req), 16'h1);
    cyc(st, 1, me, le);
  endtask

  task automatic handshake();
    do_reset();
    cyc(6'd0, 0, 0, 0);
    chk(coef_update == 16'h1000, "R2 INITIALIZE sent", coef_update, 16'h1000);
    run_eval(6'b010101, 0, 0);
    cyc(6'b010101, 0, 0, 0);
    chk(coef_update == 16'h0, "R3 INITIALIZE released", coef_update, 16'h0);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Scenario A: init handshake, saturation stop of long bin, M1 crossover stop
    do_reset();
    cyc(6'd0, 0, 0, 0);
    chk(coef_update == 16'h1000, "R2 INITIALIZE sent", coef_update, 16'h1000);
    cyc(6'd0, 0, 0, 0);
    chk(bin_eval_req == 1'b1, "R8 eval after stable word", 16'(bin_eval_req), 16'h1);
    cyc(6'd0, 1, 0, 1);
    chk(coef_update == 16'h1000, "R6 no request while INITIALIZE pending", coef_update, 16'h1000);
    cyc(6'b010100, 0, 0, 0);
    chk(coef_update[12] == 1'b1, "R3 INITIALIZE kept with a NOT_UPDATED", coef_update, 16'h1000);
    run_eval(6'b010101, 0, 0);
    cyc(6'b010101, 0, 0, 0);
    chk(coef_update == 16'h0, "R3 INITIALIZE released", coef_update, 16'h0);
    for (int k = 0; k < 3; k++) begin
      cyc(6'd0, 0, 0, 0);
      chk(coef_update[12] == 1'b0, "R2 INITIALIZE not repeated", coef_update, 16'h0);
    end
    for (int k = 0; k < 3; k++) begin
      run_eval(6'd0, 0, 1);
      chk(coef_update == 16'h0012, "R7 long-phase requests", coef_update, 16'h0012);
      cyc(6'b110001, 0, 0, 0);
      chk(coef_update == 16'h0, "R4 requests back to HOLD", coef_update, 16'h0);
    end
    run_eval(6'd0, 0, 0);
    chk(coef_update == 16'h0002, "R5 long bin stopped after three saturations", coef_update, 16'h0002);
    cyc(6'b000001, 0, 0, 0);
    run_eval(6'd0, 1, 0);
    chk(coef_update == 16'h0, "R10 M1 crossover places no request", coef_update, 16'h0);
    cyc(6'd0, 0, 0, 0);
    cyc(6'd0, 0, 0, 0);
    chk(rx_ready && tune_done, "R11 ready after both stops", 16'({rx_ready, tune_done}), 16'h3);
    cyc(6'd0, 1, 0, 0);
    chk(!bin_eval_req && rx_ready, "R11 sticky, no further evaluation",
        16'({bin_eval_req, rx_ready}), 16'h1);

    // Scenario B: M1 early holds c(-1), long crossover, M1 increment
    handshake();
    run_eval(6'd0, 1, 1);
    chk(coef_update == 16'h0010, "R7 c(-1) held while M1 early", coef_update, 16'h0010);
    cyc(6'b010000, 0, 0, 0);
    run_eval(6'd0, 1, 0);
    chk(coef_update == 16'h0, "R10 long crossover places no request", coef_update, 16'h0);
    run_eval(6'd0, 1, 0);
    chk(coef_update == 16'h0001, "R9 M1 phase increment", coef_update, 16'h0001);
    cyc(6'b000000, 0, 0, 0);
    chk(coef_update == 16'h0001, "R4 request kept while NOT_UPDATED", coef_update, 16'h0001);

    // Random phase against the bench reference
    for (int r = 0; r < 40; r++) begin
      do_reset();
      for (int c = 0; c < 300; c++) begin
        logic [5:0] st;
        st = ($urandom % 2 == 0) ? 6'd0 : 6'($urandom);
        cyc(st, 1'($urandom), 1'($urandom), 1'($urandom));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule